// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two two's-complement operands of `WIDTH` bits each and returns a signed product of `2*WIDTH` bits. It works one multiplier bit per clock and uses radix-2 Booth recoding.

A working register of `2*WIDTH+1` bits holds three things side by side:

- an accumulator in the upper `WIDTH` bits;
- the multiplier in the lower `WIDTH` bits;
- one guard bit to the right of the multiplier.

On each step the block looks at the lowest multiplier bit and the guard bit. A pair of 1 then 0 marks the start of a run of ones, so the multiplicand is subtracted from the accumulator. A pair of 0 then 1 marks the end of a run, so the multiplicand is added. Any other pair leaves the accumulator unchanged. The whole register then shifts right by one place, copying the sign bit into the vacated top position.

A one-cycle `start` pulse loads the operands while the block is idle. `busy` then stays high for exactly `WIDTH` clocks. `done` pulses for one cycle when the result is ready. The result stays on `product` until the next accepted start.

A control state machine has two states:

- `ST_IDLE`: waiting for work. The transition `idle->run` is taken when `start` is high.
- `ST_RUN`: one Booth step per clock. The transition `run->run` is taken while steps remain, and `run->idle` is taken on the final step, which also raises `done`.

Top module: `booth_seq_mul`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `busy`=0, `done`=0 and `product`=0.
- R2: A `start` pulse seen at a clock edge while idle loads the operands, and `busy` is 1 in the following cycle.
- R3: `busy` stays high for exactly `WIDTH` consecutive cycles per multiplication, so each step takes one clock.
- R4: `done` is high for exactly one cycle. That cycle is the first cycle after `busy` falls.
- R5: A `start` pulse seen while `busy` is high is ignored. The result is that of the operands loaded at the accepted start.
- R6: In the `done` cycle, `product` equals the two's-complement product of `mcand` and `mplier` as sampled at the accepted start (for example 2*7 = 8'b00001110 and 2*(-3) = 8'b11111010 at `WIDTH`=4).
- R7: The most negative operand value is handled on either input and on both together (-8*-8 = 64 at `WIDTH`=4). This works because the accumulator update uses `WIDTH+1` bits.
- R8: While idle and with no `start`, `product` keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication (honoured only when idle) |
| mcand | input | WIDTH | Multiplicand, two's complement |
| mplier | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse, result valid |
| product | output | 2*WIDTH | Signed product |

## Verification
The bench first uses the two worked cases 2*7 and 2*(-3). These tell a correct Booth recoding apart from plain shift-and-add, which gets the negative multiplier wrong. Every operand pair at the default width is then applied, including pairs with the most negative value on either side. These expose a sign lost in an accumulator only `WIDTH` bits wide and a logical shift used in place of an arithmetic one. One multiplication receives a second `start` with different operands mid-run, which separates an ignored request from one that reloads the register. Holding `product` across idle gaps shows whether the register drifts when no work is pending.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } step_op_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_mul_pkg::*;
(
    input  logic     cur_bit,
    input  logic     right_bit,
    output step_op_t op
);
    always_comb begin
        unique case ({cur_bit, right_bit})
            2'b10:   op = OP_SUB;   // run of ones begins
            2'b01:   op = OP_ADD;   // run of ones has ended
            default: op = OP_HOLD;  // inside a run of ones or of zeros
        endcase
    end
endmodule

// File: rtl/booth_step.sv
module booth_step
    import booth_mul_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] low_in,
    input  logic             guard_in,
    input  logic [WIDTH-1:0] mcand,
    output logic [WIDTH-1:0] acc_out,
    output logic [WIDTH-1:0] low_out,
    output logic             guard_out
);
    localparam int EXT_W = WIDTH + 1;

    step_op_t         op;
    logic [EXT_W-1:0] acc_ext;
    logic [EXT_W-1:0] mc_ext;
    logic [EXT_W-1:0] acc_new;

    booth_recode u_recode (
        .cur_bit  (low_in[0]),
        .right_bit(guard_in),
        .op       (op)
    );

    assign acc_ext = {acc_in[WIDTH-1], acc_in};
    assign mc_ext  = {mcand[WIDTH-1], mcand};

    always_comb begin
        unique case (op)
            OP_ADD:  acc_new = acc_ext + mc_ext;
            OP_SUB:  acc_new = acc_ext - mc_ext;
            default: acc_new = acc_ext;
        endcase
    end

    // Arithmetic right shift of {acc_new, low_in, guard_in} by one place.
    // acc_new is one bit wider than the accumulator, so its top bit is
    // the sign that is copied in from the left.
    assign acc_out   = acc_new[EXT_W-1:1];
    assign low_out   = {acc_new[0], low_in[WIDTH-1:1]};
    assign guard_out = low_in[0];
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_mul_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int              CNT_W = $clog2(WIDTH) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    mul_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_step;

    assign load      = (state_q == ST_IDLE) && start;
    assign step      = (state_q == ST_RUN);
    assign busy      = step;
    assign last_step = step && (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_RUN;   // idle->run
            ST_RUN:  if (last_step) state_d = ST_IDLE;  // run->idle
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register and step counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load)      cnt_q <= '0;
            else if (step) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output register: done pulses in the cycle after the last step.
    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= last_step;
    end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_mul_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic             load, step;
    logic [WIDTH-1:0] acc_q, low_q, mc_q;
    logic             guard_q;
    logic [WIDTH-1:0] acc_d, low_d;
    logic             guard_d;

    booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .load (load),
        .step (step),
        .busy (busy),
        .done (done)
    );

    booth_step #(.WIDTH(WIDTH)) u_step (
        .acc_in   (acc_q),
        .low_in   (low_q),
        .guard_in (guard_q),
        .mcand    (mc_q),
        .acc_out  (acc_d),
        .low_out  (low_d),
        .guard_out(guard_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            low_q   <= '0;
            guard_q <= 1'b0;
            mc_q    <= '0;
        end else if (load) begin
            acc_q   <= '0;
            low_q   <= mplier;
            guard_q <= 1'b0;
            mc_q    <= mcand;
        end else if (step) begin
            acc_q   <= acc_d;
            low_q   <= low_d;
            guard_q <= guard_d;
        end
    end

    assign product = {acc_q, low_q};
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int WIDTH = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [WIDTH-1:0]   mcand,
    input logic [WIDTH-1:0]   mplier,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    localparam int LEN_W = $clog2(WIDTH) + 2;

    logic [LEN_W-1:0]          busy_len;
    logic signed [2*WIDTH-1:0] exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len <= '0;
            exp_q    <= '0;
        end else begin
            busy_len <= busy ? busy_len + 1'b1 : '0;
            if (!busy && start)
                exp_q <= $signed(mcand) * $signed(mplier);
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!busy && !done && product == '0));

    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    a_r3_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == LEN_W'(WIDTH)));

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(busy));

    a_r6_product: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == exp_q));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/booth_seq_mul_bench.sv
module booth_seq_mul_bench;
    localparam int W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [W-1:0]     mcand = '0;
    logic [W-1:0]     mplier = '0;
    logic             busy, done;
    logic [2*W-1:0]   product;

    int checks = 0;
    int fails = 0;
    bit go = 0;
    string tag = "R6";

    // Behavioural reference state.
    bit        m_busy = 0, m_done = 0, m_have = 0, m_post_reset = 0;
    int        m_cnt = 0;
    longint    m_exp = 0;

    always #5 clk = ~clk;

    booth_seq_mul #(.WIDTH(W)) u_booth_seq_mul (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand),
        .mplier(mplier), .busy(busy), .done(done), .product(product)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_have <= 1; m_exp <= 0;
            m_cnt <= 0; m_post_reset <= 1;
        end else if (!m_busy) begin
            m_done <= 0;
            if (start) begin
                m_busy <= 1; m_cnt <= 0; m_have <= 0; m_post_reset <= 0;
                m_exp <= longint'($signed(mcand)) * longint'($signed(mplier));
            end
        end else begin
            m_cnt <= m_cnt + 1;
            if (m_cnt == W - 1) begin
                m_busy <= 0; m_done <= 1; m_have <= 1;
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (go) begin
            check("R2,R3 busy", longint'(busy), longint'(m_busy));
            check("R4 done", longint'(done), longint'(m_done));
            if (m_have) begin
                logic [2*W-1:0] e;
                e = m_exp[2*W-1:0];
                if (m_post_reset)  check("R1 product", longint'(product), longint'(e));
                else if (m_done)   check(tag, longint'(product), longint'(e));
                else               check("R8 product hold", longint'(product), longint'(e));
            end
        end
    end

    task automatic run_mul(input int a, input int b, input bit interfere);
        @(negedge clk);
        start = 1; mcand = W'(a); mplier = W'(b);
        @(negedge clk);
        start = 0;
        if (interfere) begin
            @(negedge clk);
            start = 1; mcand = W'(a + 3); mplier = W'(b - 5);
            @(negedge clk);
            start = 0;
        end
        while (!m_done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        go = 1;
        repeat (2) @(negedge clk);
        tag = "R6"; run_mul(2, 7, 0);
        tag = "R6"; run_mul(2, -3, 0);
        tag = "R6"; run_mul(0, -5, 0);
        tag = "R7"; run_mul(-8, -8, 0);
        tag = "R7"; run_mul(-8, 7, 0);
        tag = "R7"; run_mul(7, -8, 0);
        tag = "R5"; run_mul(-3, 6, 1);
        tag = "R5"; run_mul(5, 5, 1);
        tag = "R6";
        for (int a = -(2 ** (W - 1)); a < 2 ** (W - 1); a++)
            for (int b = -(2 ** (W - 1)); b < 2 ** (W - 1); b++)
                run_mul(a, b, 0);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule